// File: doc/BRIEF.md
# Two-Level Overcurrent Fault Supervisor

This block watches the protection flags of a dual-channel H-bridge PWM controller and decides when the gate drive of each channel must be forced off. Each channel brings two current flags from external threshold comparators. The lower flag trips at about 40% above full-scale current. The upper flag trips at about 500% above full scale. The channels also share two supply flags: one for a positive supply below its trip point, and one for negative bias that is too weak. All of these flags are asynchronous. Each one is resynchronized before the logic uses it.

The lower current level is treated as possible switching noise. It must stay present for a qualification window, set in clock cycles, before it trips. The upper level trips as soon as its synchronized flag arrives. A current trip is held for a minimum interval. After that interval it releases only once both current flags of the channel are quiet. A supply fault is not held: it ends as soon as both supply flags read good.

One open-drain enable/status line is shared by both channels and by external circuitry. It appears here as a sensed input and a pull-down output. Any internal fault pulls the line low. Any low level on the line, whether internal or driven from outside, forces every channel's gate-kill output high.

Top module: `ocp_supervisor`

## Requirements
- R1: An overcurrent flag trips its channel only after it has been high for QUAL_CYC+1 consecutive synchronized samples. A pulse of QUAL_CYC samples or fewer has no effect on `kill` or `pull_low`. A trip raises that channel's `kill` QUAL_CYC+3 clock edges after the raw flag first rises.
- R2: An excess-current flag raises its channel's `kill` and `pull_low` two clock edges after the raw flag rises, with no qualification delay.
- R4: While either supply flag is high, `pull_low` and every `kill` bit are high. This condition is not latched: `pull_low` drops two edges after both flags return low.
- R5: A low level on `line_in` forces every `kill` bit high two edges later. An external low on its own leaves `pull_low` low.
- R6: A current fault on any channel drives `pull_low`. The line read back then forces the other channels' `kill` high two edges later.
- R7: Once a current fault is latched it is held for at least HOLD_CYC+1 cycles. After that it clears on the first edge where both synchronized current flags of the channel are low, and stays latched while either flag remains high.
- R8: During reset, and until the supply flags have been sampled good, every `kill` bit and `pull_low` are high. With all flags quiet they are low within ten cycles of reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_raw | input | NCH | Lower-level overcurrent flag per channel, asynchronous, active high |
| xc_raw | input | NCH | Upper-level excess-current flag per channel, asynchronous, active high |
| uv_raw | input | 1 | Positive supply below trip point, asynchronous, active high |
| bias_low_raw | input | 1 | Negative bias insufficient, asynchronous, active high |
| line_in | input | 1 | Sensed level of the shared enable/status line, low = disable |
| kill | output | NCH | Per-channel gate kill, high forces all switching outputs low |
| pull_low | output | 1 | Pull-down drive of the shared line, high = pull line low |

## Verification
The hardest state to reach is the end of a latched current fault that is still being extended by the flag itself. The overcurrent flag has to stay active well past both the qualification window and the hold interval before it is dropped. Only then can the release be seen to follow the flag rather than the timer. The bench holds one channel's flag for QUAL_CYC+HOLD_CYC+10 cycles and checks that the line is still pulled at the drop. It then counts edges to confirm the release. A further difficulty is that every release goes around the loop through the shared line and its synchronizer. The bench therefore models the open-drain line as a wired AND of the block's pull-down and an external driver, and checks the kill release two cycles after the line release.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
   typedef enum logic [1:0] {
      GRD_IDLE  = 2'd0,
      GRD_HOLD  = 2'd1,
      GRD_DRAIN = 2'd2
   } guard_state_t;

   function automatic int cnt_bits(input int limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ocp_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= d;
         else             chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ocp_cur_guard.sv
module ocp_cur_guard
   import ocp_pkg::*;
#(
   parameter int QUAL_CYC = 50,
   parameter int HOLD_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic oc_s,
   input  logic xc_s,
   output logic fault_q
);
   localparam int QW = cnt_bits(QUAL_CYC);
   localparam int HW = cnt_bits(HOLD_CYC);

   if (QUAL_CYC < 1) begin : g_bad_qual
      $error("ocp_cur_guard: QUAL_CYC must be at least 1");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("ocp_cur_guard: HOLD_CYC must be at least 1");
   end

   logic [QW-1:0] qual_cnt;
   logic [HW-1:0] hold_cnt;
   guard_state_t  state;
   logic          qual_done;
   logic          trip;
   logic          quiet;

   assign qual_done = (qual_cnt == QW'(QUAL_CYC));
   assign trip      = xc_s | (oc_s & qual_done);
   assign quiet     = ~oc_s & ~xc_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          qual_cnt <= '0;
      else if (!oc_s)      qual_cnt <= '0;
      else if (!qual_done) qual_cnt <= qual_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= GRD_IDLE;
         hold_cnt <= '0;
      end else begin
         unique case (state)
            GRD_IDLE: begin
               if (trip) begin
                  state    <= GRD_HOLD;
                  hold_cnt <= HW'(HOLD_CYC);
               end
            end
            GRD_HOLD: begin
               if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
               else if (quiet)     state    <= GRD_IDLE;
               else                state    <= GRD_DRAIN;
            end
            GRD_DRAIN: begin
               if (quiet) state <= GRD_IDLE;
            end
            default: state <= GRD_IDLE;
         endcase
      end
   end

   assign fault_q = (state != GRD_IDLE);
endmodule

// File: rtl/ocp_merge.sv
module ocp_merge #(
   parameter int NCH = 2
) (
   input  logic [NCH-1:0] fault_q,
   input  logic [NCH-1:0] xc_s,
   input  logic           supply_bad,
   input  logic           line_ok,
   output logic [NCH-1:0] kill,
   output logic           pull_low
);
   for (genvar c = 0; c < NCH; c++) begin : g_kill
      assign kill[c] = fault_q[c] | xc_s[c] | supply_bad | ~line_ok;
   end

   assign pull_low = (|fault_q) | (|xc_s) | supply_bad;
endmodule

// File: rtl/ocp_supervisor.sv
module ocp_supervisor #(
   parameter int NCH         = 2,
   parameter int QUAL_CYC    = 50,
   parameter int HOLD_CYC    = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] oc_raw,
   input  logic [NCH-1:0] xc_raw,
   input  logic           uv_raw,
   input  logic           bias_low_raw,
   input  logic           line_in,
   output logic [NCH-1:0] kill,
   output logic           pull_low
);
   if (NCH < 1) begin : g_bad_nch
      $error("ocp_supervisor: NCH must be at least 1");
   end

   localparam int CW = 2 * NCH;

   logic [CW-1:0]  cur_s;
   logic [NCH-1:0] oc_s;
   logic [NCH-1:0] xc_s;
   logic [1:0]     sup_s;
   logic           supply_bad;
   logic           line_ok;
   logic [NCH-1:0] fault_q;

   ocp_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_cur_sync (
      .clk(clk), .rst_n(rst_n), .d({xc_raw, oc_raw}), .q(cur_s));

   ocp_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sup_sync (
      .clk(clk), .rst_n(rst_n), .d({bias_low_raw, uv_raw}), .q(sup_s));

   ocp_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_line_sync (
      .clk(clk), .rst_n(rst_n), .d(line_in), .q(line_ok));

   assign oc_s       = cur_s[NCH-1:0];
   assign xc_s       = cur_s[CW-1:NCH];
   assign supply_bad = |sup_s;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      ocp_cur_guard #(.QUAL_CYC(QUAL_CYC), .HOLD_CYC(HOLD_CYC)) u_guard (
         .clk(clk), .rst_n(rst_n), .oc_s(oc_s[c]), .xc_s(xc_s[c]),
         .fault_q(fault_q[c]));
   end

   ocp_merge #(.NCH(NCH)) u_merge (
      .fault_q(fault_q), .xc_s(xc_s), .supply_bad(supply_bad),
      .line_ok(line_ok), .kill(kill), .pull_low(pull_low));
endmodule

// File: rtl/ocp_checker.sv
module ocp_checker #(
   parameter int NCH = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] oc_s,
   input logic [NCH-1:0] xc_s,
   input logic [NCH-1:0] fault_q,
   input logic           supply_bad,
   input logic           line_ok,
   input logic [NCH-1:0] kill,
   input logic           pull_low
);
   for (genvar c = 0; c < NCH; c++) begin : g_chk
      // R2: synchronized excess current kills its channel in the same cycle
      p_xc_kill_r2: assert property (@(posedge clk) disable iff (!rst_n)
         xc_s[c] |-> kill[c]);
      // R6: a latched current fault holds the shared line low
      p_fault_pull_r6: assert property (@(posedge clk) disable iff (!rst_n)
         fault_q[c] |-> pull_low);
      // R1: a latch is only entered on a current flag seen the cycle before
      p_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(fault_q[c]) |-> ($past(oc_s[c]) || $past(xc_s[c])));
      // R7: a latched fault lasts more than one cycle
      p_hold_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(fault_q[c]) |=> fault_q[c]);
      // R7: release only when both current flags were quiet
      p_clear_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(fault_q[c]) |-> (!$past(oc_s[c]) && !$past(xc_s[c])));
   end

   // R4: supply fault pulls the line and kills every channel
   p_supply_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
      supply_bad |-> (pull_low && (&kill)));
   // R5: a low line seen through the synchronizer kills every channel
   p_line_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !line_ok |-> (&kill));
endmodule

bind ocp_supervisor ocp_checker #(.NCH(NCH)) u_ocp_checker (
   .clk(clk), .rst_n(rst_n), .oc_s(oc_s), .xc_s(xc_s), .fault_q(fault_q),
   .supply_bad(supply_bad), .line_ok(line_ok), .kill(kill),
   .pull_low(pull_low));

// File: tb/tb_ocp_supervisor.sv
`timescale 1ns/1ps
module tb_ocp_supervisor;
   localparam int NCH  = 2;
   localparam int QUAL = 8;
   localparam int HOLD = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] oc_raw = '0;
   logic [NCH-1:0] xc_raw = '0;
   logic           uv_raw = 1'b0;
   logic           bias_low_raw = 1'b0;
   logic           ext_low = 1'b0;
   logic           line_in;
   logic [NCH-1:0] kill;
   logic           pull_low;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   // open-drain line: low if the block or the outside world pulls it
   assign line_in = ~(pull_low | ext_low);

   ocp_supervisor #(.NCH(NCH), .QUAL_CYC(QUAL), .HOLD_CYC(HOLD), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .xc_raw(xc_raw),
      .uv_raw(uv_raw), .bias_low_raw(bias_low_raw), .line_in(line_in),
      .kill(kill), .pull_low(pull_low));

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic t_reset();
      step(2);
      chk("R8", "kill in reset", 4'(kill), 4'b0011);
      chk("R8", "pull in reset", 4'(pull_low), 4'b0001);
      rst_n = 1'b1;
      step(10);
      chk("R8", "kill after reset", 4'(kill), 4'b0000);
      chk("R8", "pull after reset", 4'(pull_low), 4'b0000);
   endtask

   task automatic t_xc_pulse();
      step(1); xc_raw[0] = 1'b1;
      step(1); xc_raw[0] = 1'b0;
      chk("R2", "kill before sync", 4'(kill), 4'b0000);
      step(1);
      chk("R2", "kill ch0 immediate", 4'(kill), 4'b0001);
      chk("R2", "pull on excess", 4'(pull_low), 4'b0001);
      step(1);
      chk("R6", "ch1 before line sync", 4'(kill[1]), 4'b0000);
      step(1);
      chk("R6", "ch1 via line", 4'(kill), 4'b0011);
      step(HOLD - 1);
      chk("R7", "held to HOLD+3", 4'(pull_low), 4'b0001);
      step(1);
      chk("R7", "released at HOLD+4", 4'(pull_low), 4'b0000);
      step(1);
      chk("R7", "kill until line resyncs", 4'(kill[0]), 4'b0001);
      step(1);
      chk("R7", "kill released", 4'(kill), 4'b0000);
      step(4);
   endtask

   task automatic t_oc_short();
      bit seen = 1'b0;
      step(1); oc_raw[1] = 1'b1;
      step(QUAL); oc_raw[1] = 1'b0;
      for (int i = 0; i < 8; i++) begin
         step(1);
         if (pull_low || (kill != '0)) seen = 1'b1;
      end
      chk("R1", "QUAL-sample pulse ignored", 4'(seen), 4'b0000);
      step(2);
   endtask

   task automatic t_oc_trip();
      step(1); oc_raw[1] = 1'b1;
      step(QUAL + 1); oc_raw[1] = 1'b0;
      step(1);
      chk("R1", "not yet tripped", 4'(kill), 4'b0000);
      step(1);
      chk("R1", "qualified trip ch1", 4'(kill), 4'b0010);
      chk("R6", "pull on trip", 4'(pull_low), 4'b0001);
      step(1);
      chk("R6", "ch0 before line sync", 4'(kill[0]), 4'b0000);
      step(1);
      chk("R6", "ch0 via line", 4'(kill), 4'b0011);
      step(HOLD - 2);
      chk("R7", "oc held", 4'(pull_low), 4'b0001);
      step(1);
      chk("R7", "oc released", 4'(pull_low), 4'b0000);
      step(6);
   endtask

   task automatic t_oc_long();
      localparam int D = QUAL + HOLD + 10;
      step(1); oc_raw[0] = 1'b1;
      step(D);
      chk("R7", "latched while flag active", 4'(pull_low), 4'b0001);
      oc_raw[0] = 1'b0;
      step(2);
      chk("R7", "still latched at drop+2", 4'(pull_low), 4'b0001);
      step(1);
      chk("R7", "cleared at drop+3", 4'(pull_low), 4'b0000);
      step(1);
      chk("R7", "kill after drop", 4'(kill), 4'b0011);
      step(1);
      chk("R7", "kill clear after drop", 4'(kill), 4'b0000);
      step(4);
   endtask

   task automatic t_supply(input bit use_bias);
      step(1);
      if (use_bias) bias_low_raw = 1'b1; else uv_raw = 1'b1;
      step(1);
      chk("R4", "supply before sync", 4'({kill, pull_low}), 4'b0000);
      step(1);
      chk("R4", "supply kill", 4'(kill), 4'b0011);
      chk("R4", "supply pull", 4'(pull_low), 4'b0001);
      step(8);
      bias_low_raw = 1'b0; uv_raw = 1'b0;
      step(1);
      chk("R4", "supply still pulled", 4'(pull_low), 4'b0001);
      step(1);
      chk("R4", "supply not latched", 4'(pull_low), 4'b0000);
      step(1);
      chk("R4", "kill via line lag", 4'(kill), 4'b0011);
      step(1);
      chk("R4", "kill released", 4'(kill), 4'b0000);
      step(4);
   endtask

   task automatic t_ext();
      step(1); ext_low = 1'b1;
      step(1);
      chk("R5", "ext before sync", 4'(kill), 4'b0000);
      step(1);
      chk("R5", "ext kills all", 4'(kill), 4'b0011);
      chk("R5", "ext no pull", 4'(pull_low), 4'b0000);
      step(3); ext_low = 1'b0;
      step(1);
      chk("R5", "ext kill lag", 4'(kill), 4'b0011);
      step(1);
      chk("R5", "ext released", 4'(kill), 4'b0000);
      step(4);
   endtask

   initial begin
      t_reset();
      t_xc_pulse();
      t_oc_short();
      t_oc_trip();
      t_oc_long();
      t_supply(1'b0);
      t_supply(1'b1);
      t_ext();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule